// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. The page tables are held in memory in two levels, and the block walks them. A small direct-mapped translation cache is checked first. When the cache hits, the answer comes back with no memory traffic. When it misses, the block reads the directory word and then the table word over a single request/acknowledge memory port. If an entry has not been touched before, or if a write finds a clean page, the block writes the updated status bits back to the same memory word.

The two permission levels are merged into one effective view, and that view is what the cache stores. The merged view is then checked against the requester's privilege level and against the write-protect switch. The block answers with either a physical address or a page fault, and a fault carries a 3-bit code. When paging is off, the linear address is returned unchanged. The block takes one request at a time. The directory base is loaded through its own write strobe. A flush pulse, or any load of the base, empties the cache.

Top module: `pgwalk_top`

## Requirements
- R1: With `pg_en` low at acceptance, the response comes in the next cycle with `resp_paddr` equal to the request address, no fault, and no memory access.
- R2: If the cache holds a valid entry for address bits [31:12], the response uses that stored merged entry and makes no memory access.
- R3: The directory word is read at base + 4 × address[31:22]. The table word is read at (directory bits [31:12] << 12) + 4 × address[21:12].
- R4: If the present bit (bit 0) is clear at either level, the walk stops there. The result is an all-zero entry: a fault with code 0, and nothing is cached.
- R5: If the accessed bit (bit 5) of a fetched directory or table word is clear, the word is written back to the same address with that bit set, before the walk continues.
- R6: A write request sets the dirty bit (bit 6) of the table word. Whenever this changes the word, the word is written back.
- R7: The effective writable bit (bit 1) is the AND of both levels. The effective user bit (bit 2) is the AND of both levels. This merged entry is what a later hit returns.
- R8: A fault is raised when the effective user bit is clear and `req_cpl` is nonzero.
- R9: A write raises a fault when `wp_en` is high and the effective writable bit is clear. With `wp_en` low, no such fault is raised.
- R10: On a fault, `resp_code` is the merged entry's bits {user, writable, present}. Without a fault, `resp_paddr` is the entry frame shifted left by 12, ORed with address[11:0].
- R11: A `flush` pulse, or a `base_wr` pulse, invalidates every cache entry. Walks after a base load use the new base.
- R12: `mem_req` stays high with stable address and direction until `mem_ack`. `req_ready` is low from acceptance until one cycle after the single-cycle `resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Request is a write access |
| req_cpl | input | 2 | Current privilege level, 0 = most privileged |
| pg_en | input | 1 | Paging enable |
| wp_en | input | 1 | Write-protect enable |
| base_wr | input | 1 | Load the directory base; also invalidates the cache |
| base_in | input | 32 | New directory base |
| flush | input | 1 | Invalidate the cache |
| resp_valid | output | 1 | Result valid for one cycle |
| resp_fault | output | 1 | Page fault |
| resp_code | output | 3 | Fault code {user, writable, present} |
| resp_paddr | output | 32 | Physical address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest case to reach from the ports is a stale cached entry. A hit must return the merged permissions and status captured at fill time, even after the memory words beneath it have changed. A hit must also skip the dirty update on a write. The stimulus gets there by mixing random requests over a small set of page indexes, so that hits and refills interleave with random flushes. Directed sequences first fill an entry and then probe it with a different privilege level or access type. Each case is compared against a shadow copy of the cache held in the bench.

// File: rtl/pgwalk_pkg.sv
// Shared definitions for the page table walker.
// Assumes 32-bit addresses, 4 KiB pages and 4-byte table words.
package pgwalk_pkg;
    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = ADDR_W - OFF_W;
    localparam int BIT_P   = 0;
    localparam int BIT_W   = 1;
    localparam int BIT_U   = 2;
    localparam int BIT_A   = 5;
    localparam int BIT_D   = 6;

    // Reduced view of a merged entry: all that the checks and the cache need.
    typedef struct packed {
        logic [VPN_W-1:0] frame;
        logic             usr;
        logic             wrt;
        logic             prs;
    } pview_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_DIR, ST_WB_DIR, ST_RD_TBL, ST_WB_TBL, ST_DONE
    } walk_st_t;
endpackage

// File: rtl/pgwalk_tcache.sv
// Direct-mapped translation cache with a combinational lookup and a one-cycle fill.
// Assumes IDX_W is below VPN_W. Invalidation has priority over a fill in the same cycle.
module pgwalk_tcache
    import pgwalk_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output pview_t           hit_ent,
    input  logic             fill,
    input  logic [VPN_W-1:0] fill_vpn,
    input  pview_t           fill_ent
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = VPN_W - IDX_W;

    logic [ENTRIES-1:0] vld;
    logic [TAG_W-1:0]   tags [ENTRIES];
    pview_t             ents [ENTRIES];

    logic [IDX_W-1:0] look_idx, fill_idx;
    assign look_idx = look_vpn[IDX_W-1:0];
    assign fill_idx = fill_vpn[IDX_W-1:0];

    // One valid flag per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic v;
        // Valid flag: cleared by reset or invalidation, set by a fill of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || inval)                          v <= 1'b0;
            else if (fill && fill_idx == IDX_W'(g))       v <= 1'b1;
        end
        assign vld[g] = v;
    end

    // Tag and entry storage written on a fill.
    always_ff @(posedge clk) begin
        if (fill) begin
            tags[fill_idx] <= fill_vpn[VPN_W-1:IDX_W];
            ents[fill_idx] <= fill_ent;
        end
    end

    // Lookup: hit when the slot is valid and its tag matches.
    always_comb begin
        hit     = vld[look_idx] && (tags[look_idx] == look_vpn[VPN_W-1:IDX_W]);
        hit_ent = ents[look_idx];
    end
endmodule

// File: rtl/pgwalk_perm.sv
// Privilege and write-protect check on a merged entry, plus physical address forming.
// Assumes an entry that is not present has every field at zero.
module pgwalk_perm
    import pgwalk_pkg::*;
(
    input  pview_t            ent,
    input  logic              is_write,
    input  logic [1:0]        cpl,
    input  logic              wp,
    input  logic [OFF_W-1:0]  off,
    output logic              fault,
    output logic [2:0]        code,
    output logic [ADDR_W-1:0] paddr
);
    // Fault decision and outputs derived from the entry.
    always_comb begin
        fault = !ent.prs
              || (!ent.usr && (cpl != 2'd0))
              || (is_write && wp && !ent.wrt);
        code  = {ent.usr, ent.wrt, ent.prs};
        paddr = {ent.frame, off};
    end
endmodule

// File: rtl/pgwalk_top.sv
// Two-level page table walker: cache lookup, directory and table walk with status
// write-back, merged permissions, fault reporting. One request in flight at a time.
// Assumes the memory returns read data in the cycle it raises mem_ack.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int CACHE_IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_cpl,
    input  logic              pg_en,
    input  logic              wp_en,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              flush,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [2:0]        resp_code,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1) << BIT_A;
    localparam logic [ADDR_W-1:0] D_MASK = ADDR_W'(1) << BIT_D;

    walk_st_t          st;
    logic [ADDR_W-1:0] va_q, base_q, madr_q, wdata_q;
    logic              wr_q, wp_q, bypass_q;
    logic [1:0]        cpl_q;
    logic [VPN_W-1:0]  dframe_q;
    logic              dw_q, du_q;
    pview_t            ent_q;

    logic              hit, fill;
    pview_t            hit_ent, merged;
    logic [ADDR_W-1:0] tbl_src, tbl_new;
    logic              pfault;
    logic [2:0]        pcode;
    logic [ADDR_W-1:0] ppaddr;

    // Table word with the status bits this access must set, and its merged view.
    always_comb begin
        tbl_new       = mem_rdata | A_MASK | (wr_q ? D_MASK : '0);
        tbl_src       = (st == ST_WB_TBL) ? wdata_q : tbl_new;
        merged.frame  = tbl_src[ADDR_W-1:OFF_W];
        merged.prs    = tbl_src[BIT_P];
        merged.wrt    = tbl_src[BIT_W] & dw_q;
        merged.usr    = tbl_src[BIT_U] & du_q;
        fill          = ((st == ST_RD_TBL) && mem_ack && mem_rdata[BIT_P] && (tbl_new == mem_rdata))
                     || ((st == ST_WB_TBL) && mem_ack);
    end

    pgwalk_tcache #(.IDX_W(CACHE_IDX_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .inval    (flush || base_wr),
        .look_vpn (req_addr[ADDR_W-1:OFF_W]),
        .hit      (hit),
        .hit_ent  (hit_ent),
        .fill     (fill),
        .fill_vpn (va_q[ADDR_W-1:OFF_W]),
        .fill_ent (merged)
    );

    pgwalk_perm u_perm (
        .ent      (ent_q),
        .is_write (wr_q),
        .cpl      (cpl_q),
        .wp       (wp_q),
        .off      (va_q[OFF_W-1:0]),
        .fault    (pfault),
        .code     (pcode),
        .paddr    (ppaddr)
    );

    // Directory base register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_wr) base_q <= base_in;
    end

    // Walk state machine with its captured request and entry registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            va_q     <= '0;
            wr_q     <= 1'b0;
            wp_q     <= 1'b0;
            cpl_q    <= '0;
            bypass_q <= 1'b0;
            madr_q   <= '0;
            wdata_q  <= '0;
            dframe_q <= '0;
            dw_q     <= 1'b0;
            du_q     <= 1'b0;
            ent_q    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    va_q     <= req_addr;
                    wr_q     <= req_write;
                    wp_q     <= wp_en;
                    cpl_q    <= req_cpl;
                    bypass_q <= !pg_en;
                    if (!pg_en) begin
                        st <= ST_DONE;
                    end else if (hit) begin
                        ent_q <= hit_ent;
                        st    <= ST_DONE;
                    end else begin
                        madr_q <= base_q + {20'd0, req_addr[31:22], 2'b00};
                        st     <= ST_RD_DIR;
                    end
                end
                ST_RD_DIR: if (mem_ack) begin
                    dframe_q <= mem_rdata[ADDR_W-1:OFF_W];
                    dw_q     <= mem_rdata[BIT_W];
                    du_q     <= mem_rdata[BIT_U];
                    if (!mem_rdata[BIT_P]) begin
                        ent_q <= '0;
                        st    <= ST_DONE;
                    end else if (!mem_rdata[BIT_A]) begin
                        wdata_q <= mem_rdata | A_MASK;
                        st      <= ST_WB_DIR;
                    end else begin
                        madr_q <= {mem_rdata[ADDR_W-1:OFF_W], va_q[21:12], 2'b00};
                        st     <= ST_RD_TBL;
                    end
                end
                ST_WB_DIR: if (mem_ack) begin
                    madr_q <= {dframe_q, va_q[21:12], 2'b00};
                    st     <= ST_RD_TBL;
                end
                ST_RD_TBL: if (mem_ack) begin
                    if (!mem_rdata[BIT_P]) begin
                        ent_q <= '0;
                        st    <= ST_DONE;
                    end else if (tbl_new != mem_rdata) begin
                        wdata_q <= tbl_new;
                        st      <= ST_WB_TBL;
                    end else begin
                        ent_q <= merged;
                        st    <= ST_DONE;
                    end
                end
                ST_WB_TBL: if (mem_ack) begin
                    ent_q <= merged;
                    st    <= ST_DONE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from state and captured results.
    always_comb begin
        req_ready  = (st == ST_IDLE);
        resp_valid = (st == ST_DONE);
        resp_fault = !bypass_q && pfault;
        resp_code  = bypass_q ? 3'd0 : pcode;
        resp_paddr = bypass_q ? va_q : ppaddr;
        mem_req    = (st == ST_RD_DIR) || (st == ST_WB_DIR) || (st == ST_RD_TBL) || (st == ST_WB_TBL);
        mem_we     = (st == ST_WB_DIR) || (st == ST_WB_TBL);
        mem_addr   = madr_q;
        mem_wdata  = wdata_q;
    end
endmodule

// File: rtl/pgwalk_chk.sv
// Protocol and pass-through checks for pgwalk_top, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module pgwalk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        pg_en,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic [31:0] resp_paddr,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack
);
    a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready && !resp_valid);

    a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid && req_ready);

    a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !pg_en |=> resp_valid && !resp_fault && resp_paddr == $past(req_addr));

    a_r5_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[5] && mem_wdata[0]);
endmodule

bind pgwalk_top pgwalk_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .pg_en      (pg_en),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/sim_pgwalk_top.sv
`timescale 1ns/1ps
module sim_pgwalk_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0] req_cpl = '0;
    logic pg_en = 1'b0, wp_en = 1'b0, base_wr = 1'b0, flush = 1'b0;
    logic [31:0] base_in = '0;
    logic resp_valid, resp_fault;
    logic [2:0] resp_code;
    logic [31:0] resp_paddr;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

    int n_chk = 0, n_fail = 0, n_acc = 0, cycles = 0, lat = 0;
    logic [31:0] mem [0:4095];
    logic [31:0] cur_base = '0;
    bit          sh_v [16];
    logic [15:0] sh_t [16];
    logic [31:0] sh_e [16];

    always #2.5 clk = ~clk;

    pgwalk_top u0 (.*);

    // Memory responder: random latency, acknowledges on the falling edge.
    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (lat == 0) begin
                mem_ack   = 1'b1;
                mem_rdata = mem[mem_addr[13:2]];
                if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
                n_acc++;
                lat = $urandom_range(0, 2);
            end else lat--;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk) flush = 1'b1;
        @(negedge clk) flush = 1'b0;
        foreach (sh_v[i]) sh_v[i] = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk) begin base_wr = 1'b1; base_in = b; end
        @(negedge clk) base_wr = 1'b0;
        cur_base = b;
        foreach (sh_v[i]) sh_v[i] = 1'b0;
    endtask

    // Computes the expected result from the requirements, issues the request, compares.
    task automatic run_req(input logic [31:0] a, input bit w, input logic [1:0] c,
                           input bit wp, input bit pg, input string tag);
        logic [31:0] ent = '0, dw = '0, tw = '0, t2, pa, da = '0, ta = '0;
        int acc = 0, start, waitc = 0;
        bit f = 1'b0, chk_d = 1'b0, chk_t = 1'b0, busy_seen = 1'b0;
        if (!pg) pa = a;
        else begin
            if (sh_v[a[15:12]] && sh_t[a[15:12]] == a[31:16]) ent = sh_e[a[15:12]];
            else begin
                da = cur_base + {20'd0, a[31:22], 2'b00};
                dw = mem[da[13:2]]; acc++;
                if (dw[0]) begin
                    if (!dw[5]) begin dw[5] = 1'b1; acc++; end
                    chk_d = 1'b1;
                    ta = {dw[31:12], a[21:12], 2'b00};
                    tw = mem[ta[13:2]]; acc++;
                    if (tw[0]) begin
                        t2 = tw | 32'h20 | (w ? 32'h40 : 32'h0);
                        if (t2 != tw) acc++;
                        tw = t2; chk_t = 1'b1;
                        ent = tw; ent[1] = tw[1] & dw[1]; ent[2] = tw[2] & dw[2];
                        sh_v[a[15:12]] = 1'b1; sh_t[a[15:12]] = a[31:16]; sh_e[a[15:12]] = ent;
                    end
                end
            end
            f  = !ent[0] || (!ent[2] && c != 2'd0) || (w && wp && !ent[1]);
            pa = {ent[31:12], a[11:0]};
        end
        start = n_acc;
        @(negedge clk) begin
            req_valid = 1'b1; req_addr = a; req_write = w; req_cpl = c; wp_en = wp; pg_en = pg;
        end
        @(negedge clk) req_valid = 1'b0;
        while (!resp_valid && waitc < 200) begin
            if (req_ready) busy_seen = 1'b1;
            @(negedge clk); waitc++;
        end
        check(resp_valid, {tag, " R12 response arrives"}, 32'(resp_valid), 32'd1);
        check(!busy_seen, {tag, " R12 ready low while busy"}, 32'(busy_seen), 32'd0);
        check(resp_fault == f, {tag, " fault flag"}, 32'(resp_fault), 32'(f));
        if (f) check(resp_code == ent[2:0], {tag, " R10 fault code"}, 32'(resp_code), 32'(ent[2:0]));
        else   check(resp_paddr == pa, {tag, " R10 physical address"}, resp_paddr, pa);
        check(n_acc - start == acc, {tag, " R3 memory access count"}, 32'(n_acc - start), 32'(acc));
        if (chk_d) check(mem[da[13:2]] == dw, {tag, " R5 directory word"}, mem[da[13:2]], dw);
        if (chk_t) check(mem[ta[13:2]] == tw, {tag, " R6 table word"}, mem[ta[13:2]], tw);
        @(negedge clk);
        check(req_ready == 1'b1, {tag, " R12 ready after response"}, 32'(req_ready), 32'd1);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!resp_valid && req_ready && !mem_req, "R12 reset state",
              {29'd0, resp_valid, req_ready, mem_req}, 32'h2);
        set_base(32'h1000);

        // R1: paging disabled.
        run_req(32'hdead_beef, 1'b1, 2'd3, 1'b1, 1'b0, "R1");

        // R4: directory entry not present, then table entry not present.
        mem[12'h401] = 32'h0000_3000;
        run_req(32'h0040_0123, 1'b0, 2'd0, 1'b0, 1'b1, "R4 dir");
        mem[12'h400] = 32'h0000_2027;
        mem[12'h805] = 32'h0000_5000;
        run_req(32'h0000_5abc, 1'b0, 2'd0, 1'b0, 1'b1, "R4 tbl");

        // R5: accessed bits clear at both levels; R2: hit repeats with no memory traffic.
        mem[12'h400] = 32'h0000_2007;
        mem[12'h806] = 32'h0001_2007;
        run_req(32'h0000_6123, 1'b0, 2'd0, 1'b0, 1'b1, "R5");
        run_req(32'h0000_6fff, 1'b0, 2'd0, 1'b0, 1'b1, "R2");

        // R6: write on a clean page sets dirty.
        mem[12'h807] = 32'h0003_3027;
        run_req(32'h0000_7010, 1'b1, 2'd0, 1'b0, 1'b1, "R6");

        // R7 and R8: user bit clear in the directory only.
        mem[12'h401] = 32'h0000_3023;
        mem[12'hc01] = 32'h0004_4067;
        run_req(32'h0040_1444, 1'b0, 2'd3, 1'b0, 1'b1, "R8");
        run_req(32'h0040_1444, 1'b0, 2'd0, 1'b0, 1'b1, "R7");
        mem[12'hc01] = 32'h0009_9067;
        run_req(32'h0040_1448, 1'b0, 2'd1, 1'b0, 1'b1, "R7 stale hit");

        // R9: writable bit clear in the directory, write protection on then off.
        do_flush();
        mem[12'h400] = 32'h0000_2025;
        mem[12'h808] = 32'h0005_5067;
        run_req(32'h0000_8000, 1'b1, 2'd0, 1'b1, 1'b1, "R9 wp on");
        run_req(32'h0000_8004, 1'b1, 2'd0, 1'b0, 1'b1, "R9 wp off");

        // R11: flush forces a new walk; a base load switches directories.
        do_flush();
        run_req(32'h0000_8008, 1'b0, 2'd0, 1'b0, 1'b1, "R11 flush");
        mem[12'h000] = 32'h0000_3027;
        mem[12'hc01] = 32'h0006_6027;
        set_base(32'h0000_0000);
        run_req(32'h0000_1234, 1'b0, 2'd0, 1'b0, 1'b1, "R11 base");
        set_base(32'h1000);

        // Random phase over a small page set so hits and refills interleave.
        for (int i = 0; i < 2048; i++)
            mem[12'h800 + i] = {$urandom_range(0, 32'hfffff) & 32'hfffff, 12'd0}
                             | ($urandom & 32'h7f) | (($urandom % 8 != 0) ? 32'h1 : 32'h0);
        mem[12'h400] = 32'h0000_2000 | ($urandom & 32'h7e) | 32'h1;
        mem[12'h401] = 32'h0000_3000 | ($urandom & 32'h7f);
        do_flush();
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            a = {9'd0, 1'($urandom), 10'($urandom % 24), 12'($urandom)};
            if ($urandom % 16 == 0) do_flush();
            run_req(a, 1'($urandom), 2'($urandom), 1'($urandom), ($urandom % 10 != 0), "R7 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule